// File: doc/BRIEF.md
# Mouse Motion Packet Encoder

This block turns one mouse report (two signed motion deltas and three button states) into a fixed five-byte packet and hands the bytes one at a time to a downstream byte queue over a valid/ready handshake. The header byte carries the buttons as active-low flags. The two motion bytes carry the horizontal delta and the negated vertical delta, each clamped symmetrically to ±127. Two zero bytes close every packet.

A report is taken only while the encoder is idle. Accepting it captures every field, so the report inputs are free to change while the packet drains. `busy_o` stays high from acceptance until the downstream side takes the fifth byte. A report offered while `busy_o` is high is dropped without effect.

Top module: `mouse_pkt_enc`

## Requirements
- R1: After reset `busy_o` and `byte_valid_o` are 0.
- R2: A cycle with `rpt_valid_i`=1 and `busy_o`=0 accepts the report. From the next cycle `busy_o`=1, `byte_valid_o`=1 and the header byte is on `byte_o`.
- R3: The header byte is 0x87 with bit 2 cleared when left is pressed, bit 1 cleared when middle is pressed and bit 0 cleared when right is pressed.
- R4: The second byte is the horizontal delta clamped to −127..+127 and sent as 8-bit two's complement. Inputs above +127 give 0x7F and inputs below −127 give 0x81.
- R5: The third byte is the negated vertical delta, clamped the same way. The most negative input value gives 0x7F.
- R6: The fourth and fifth bytes are always 0x00.
- R7: A byte is taken only in a cycle with `byte_valid_o`=1 and `byte_ready_i`=1. While `byte_ready_i` is 0, `byte_o` and `byte_valid_o` hold.
- R8: Bytes leave strictly in the order header, X, Y, zero, zero. `busy_o` and `byte_valid_o` fall in the cycle after the fifth byte is taken.
- R9: While `busy_o`=1, report pulses and changes on the delta and button inputs do not alter the packet being sent, and the dropped report produces no bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rpt_valid_i | input | 1 | Report strobe |
| dx_i | input | DELTA_W | Signed horizontal delta |
| dy_i | input | DELTA_W | Signed vertical delta |
| btn_left_i | input | 1 | Left button pressed |
| btn_mid_i | input | 1 | Middle button pressed |
| btn_right_i | input | 1 | Right button pressed |
| busy_o | output | 1 | Packet in progress |
| byte_o | output | 8 | Packet byte |
| byte_valid_o | output | 1 | `byte_o` is valid |
| byte_ready_i | input | 1 | Downstream takes the byte |

## Verification
The bench drives the clamp edges: ±127, ±128, the full-scale values and the most negative input. It also negates the vertical delta at those points. A missing negation, an off-by-one clamp or a −128 output appears as a wrong motion byte. All eight button combinations are sent, so a bit that is swapped or not inverted shows up in the header. A random ready pattern stalls the stream in every byte position, which exposes skipped or repeated bytes and a busy flag that falls one byte early. Reports and delta changes offered mid-packet, including in the cycle the last byte leaves, would show up as extra or corrupted bytes if the design did not drop them.

// File: rtl/mpe_pkg.sv
package mpe_pkg;
  localparam int unsigned PKT_BYTES = 5;
  localparam int unsigned IDX_W     = $clog2(PKT_BYTES);
  localparam logic [7:0]  HDR_BASE  = 8'h87;

  typedef logic [7:0] byte_t;

  typedef struct packed {
    byte_t hdr;
    byte_t xb;
    byte_t yb;
  } pkt_t;
endpackage

// File: rtl/mpe_clamp.sv
module mpe_clamp #(
  parameter int unsigned IN_W   = 10,
  parameter bit          NEGATE = 1'b0
) (
  input  logic signed [IN_W-1:0] d_i,
  output logic [7:0]             q_o
);
  localparam logic signed [IN_W:0] POS_LIM = (IN_W+1)'(127);
  localparam logic signed [IN_W:0] NEG_LIM = -POS_LIM;

  logic signed [IN_W:0] ext;
  logic signed [IN_W:0] val;

  assign ext = {d_i[IN_W-1], d_i};

  generate
    if (NEGATE) begin : g_neg
      assign val = -ext;
    end else begin : g_pos
      assign val = ext;
    end
  endgenerate

  always_comb begin
    if (val > POS_LIM)      q_o = 8'h7f;
    else if (val < NEG_LIM) q_o = 8'h81;
    else                    q_o = val[7:0];
  end

  // R4 R5
  always_comb begin
    no_minus128_chk: assert (q_o != 8'h80);
  end
endmodule

// File: rtl/mpe_seq.sv
module mpe_seq
  import mpe_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rpt_valid_i,
  input  logic             ready_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(PKT_BYTES - 1);

  logic             busy_q;
  logic [IDX_W-1:0] idx_q;

  assign accept_o = rpt_valid_i & ~busy_q;
  assign busy_o   = busy_q;
  assign idx_o    = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else if (busy_q && ready_i) begin
      if (idx_q == LAST) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  // R2
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rpt_valid_i && !busy_q) |=> (busy_q && idx_q == '0));

  // R7
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !ready_i) |=> (busy_q && $stable(idx_q)));

  // R8
  last_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && ready_i && idx_q == LAST) |=> !busy_q);

  // R8
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && ready_i && idx_q != LAST) |=> (busy_q && idx_q == $past(idx_q) + 1'b1));
endmodule

// File: rtl/mpe_sel.sv
module mpe_sel
  import mpe_pkg::*;
(
  input  pkt_t             pkt_i,
  input  logic [IDX_W-1:0] idx_i,
  output byte_t            byte_o
);
  always_comb begin
    case (idx_i)
      IDX_W'(0): byte_o = pkt_i.hdr;
      IDX_W'(1): byte_o = pkt_i.xb;
      IDX_W'(2): byte_o = pkt_i.yb;
      default:   byte_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/mouse_pkt_enc.sv
module mouse_pkt_enc
  import mpe_pkg::*;
#(
  parameter int unsigned DELTA_W = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rpt_valid_i,
  input  logic [DELTA_W-1:0] dx_i,
  input  logic [DELTA_W-1:0] dy_i,
  input  logic               btn_left_i,
  input  logic               btn_mid_i,
  input  logic               btn_right_i,
  output logic               busy_o,
  output logic [7:0]         byte_o,
  output logic               byte_valid_o,
  input  logic               byte_ready_i
);
  logic             accept;
  logic             busy;
  logic [IDX_W-1:0] idx;
  byte_t            x_enc, y_enc;
  pkt_t             pkt_d, pkt_q;

  mpe_clamp #(.IN_W(DELTA_W), .NEGATE(1'b0)) u_clamp_x (
    .d_i ($signed(dx_i)),
    .q_o (x_enc)
  );

  mpe_clamp #(.IN_W(DELTA_W), .NEGATE(1'b1)) u_clamp_y (
    .d_i ($signed(dy_i)),
    .q_o (y_enc)
  );

  // buttons are active low in the header
  assign pkt_d.hdr = HDR_BASE & ~{5'b0, btn_left_i, btn_mid_i, btn_right_i};
  assign pkt_d.xb  = x_enc;
  assign pkt_d.yb  = y_enc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pkt_q <= '0;
    else if (accept) pkt_q <= pkt_d;
  end

  mpe_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rpt_valid_i (rpt_valid_i),
    .ready_i     (byte_ready_i),
    .accept_o    (accept),
    .busy_o      (busy),
    .idx_o       (idx)
  );

  mpe_sel u_sel (
    .pkt_i  (pkt_q),
    .idx_i  (idx),
    .byte_o (byte_o)
  );

  assign busy_o       = busy;
  assign byte_valid_o = busy;

  // R7
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_o && !byte_ready_i) |=> (byte_valid_o && $stable(byte_o)));

  // R9
  pkt_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> $stable(pkt_q));

  // R3
  hdr_form_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_o && idx == '0) |-> (byte_o[7:3] == 5'b10000));

  // R6
  pad_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_o && idx >= IDX_W'(3)) |-> (byte_o == 8'h00));
endmodule

// File: tb/tb_mouse_pkt_enc.sv
`timescale 1ns/1ps
module tb_mouse_pkt_enc;
  localparam int DW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rpt_valid = 1'b0;
  logic [DW-1:0] dx = '0, dy = '0;
  logic          bl = 1'b0, bm = 1'b0, br = 1'b0;
  logic          busy, bvalid, bready = 1'b0;
  logic [7:0]    bdata;

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit    done = 1'b0;
  byte   exp_q[$];

  always #2.5 clk = ~clk;

  mouse_pkt_enc #(.DELTA_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .rpt_valid_i(rpt_valid),
    .dx_i(dx), .dy_i(dy), .btn_left_i(bl), .btn_mid_i(bm), .btn_right_i(br),
    .busy_o(busy), .byte_o(bdata), .byte_valid_o(bvalid), .byte_ready_i(bready)
  );

  function automatic byte clamp8(int v);
    if (v > 127) v = 127;
    if (v < -127) v = -127;
    return byte'(v & 8'hff);
  endfunction

  // behavioural reference: queue of expected bytes
  always @(posedge clk) begin
    if (!rst_n) exp_q.delete();
    else if (exp_q.size() != 0) begin
      if (bready) void'(exp_q.pop_front());
    end else if (rpt_valid) begin
      int sx, sy;
      sx = $signed(dx);
      sy = $signed(dy);
      exp_q.push_back(byte'(8'h87 ^ {5'b0, bl, bm, br}));
      exp_q.push_back(clamp8(sx));
      exp_q.push_back(clamp8(-sy));
      exp_q.push_back(8'h00);
      exp_q.push_back(8'h00);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit    ev;
      byte   eb;
      ev = exp_q.size() != 0;
      eb = ev ? exp_q[0] : 8'h00;
      n_chk++;
      if (bvalid !== ev || busy !== ev || (ev && bdata !== eb)) begin
        n_fail++;
        $display("FAIL %s: valid=%0b busy=%0b byte=%02h expected valid=%0b busy=%0b byte=%02h",
                 cur_req, bvalid, busy, bdata, ev, ev, eb);
      end
    end
  end

  task automatic send(input int x, input int y, input bit l, m, r);
    @(negedge clk);
    dx = DW'(x); dy = DW'(y); bl = l; bm = m; br = r;
    rpt_valid = 1'b1;
    @(negedge clk);
    rpt_valid = 1'b0;
    dx = DW'(x + 3); dy = DW'(y - 5); bl = ~l; // changes after accept are ignored (R9)
  endtask

  task automatic drain();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    bready = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    n_chk++;
    if (busy !== 1'b0 || bvalid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: busy=%0b valid=%0b expected 0 0", busy, bvalid);
    end
    rst_n = 1'b1;
    @(negedge clk);

    cur_req = "R2/R8 nominal";
    send(5, 9, 0, 0, 0); drain();
    cur_req = "R3 buttons";
    for (int b = 0; b < 8; b++) begin
      send(b, -b, b[2], b[1], b[0]); drain();
    end
    cur_req = "R4 X clamp";
    send(127, 0, 0, 0, 0);  drain();
    send(128, 0, 0, 0, 0);  drain();
    send(-127, 0, 0, 0, 0); drain();
    send(-128, 0, 0, 0, 0); drain();
    send(511, 0, 0, 0, 0);  drain();
    send(-512, 0, 0, 0, 0); drain();
    cur_req = "R5 Y negate clamp";
    send(0, 127, 0, 0, 0);  drain();
    send(0, -127, 0, 0, 0); drain();
    send(0, 128, 0, 0, 0);  drain();
    send(0, -128, 0, 0, 0); drain();
    send(0, -512, 0, 0, 0); drain();
    send(0, 511, 0, 0, 0);  drain();
    cur_req = "R6 R7 stalls";
    for (int k = 0; k < 40; k++) begin
      fork
        send($urandom_range(0, 1023) - 512, $urandom_range(0, 1023) - 512,
             1'($urandom), 1'($urandom), 1'($urandom));
        repeat (14) begin
          @(negedge clk);
          bready = 1'($urandom);
        end
      join
      bready = 1'b1;
      drain();
    end
    cur_req = "R9 report while busy";
    bready = 1'b0;
    send(10, 20, 1, 0, 1);
    repeat (3) begin
      @(negedge clk);
      rpt_valid = 1'b1; dx = DW'(-300); dy = DW'(300);
    end
    @(negedge clk);
    rpt_valid = 1'b0;
    bready = 1'b1;
    // offer a report in the cycle the last byte is taken
    while (!(busy && dut.byte_o == 8'h00 && exp_q.size() == 1)) @(negedge clk);
    rpt_valid = 1'b1; dx = DW'(7);
    @(negedge clk);
    rpt_valid = 1'b0;
    drain();
    cur_req = "R8 back to back";
    for (int k = 0; k < 4; k++) begin
      send(k * 40, k * -40, 1'(k), 0, 0);
      while (busy) @(negedge clk);
    end
    drain();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule